// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind a two-wire serial memory's protocol engine and owns the write path into a small non-volatile style array. The engine hands it a starting word address, a strobe for each received data byte and a strobe when the bus transaction ends. Bytes are staged in a sixteen-slot page buffer. Only the low address bits step as bytes arrive, so a long burst wraps inside one page and later bytes replace earlier ones in the same slots.

Nothing is written to the array while bytes are still arriving. The end-of-transaction strobe starts a self-timed write cycle. During the cycle the staged slots are copied into the array, and a busy flag stays high for a programmable number of clock cycles. A write-protect input blocks all programming. A separate registered read port gives the engine access to the array contents at all times.

Top module: `page_write_buffer`

## Requirements
- R1: After synchronous reset, `busy` and `arr_we` are low.
- R2: A data byte goes to the buffer slot given by the low PAGE_W bits of the current pointer. Those low bits then advance by one modulo 16, and the upper address bits do not change. Every commit address keeps the page bits of the loaded address.
- R3: When more than 16 bytes arrive before the end strobe, the pointer wraps within the page. A later byte replaces the earlier byte held in the same slot.
- R4: Neither the array nor `arr_we` changes before `stop_stb`. An accepted `stop_stb` with at least one staged byte and `wp` low raises `busy` on the next cycle. `busy` then stays high for exactly WR_CYCLES cycles.
- R5: A commit writes only the slots loaded in that transaction. It gives exactly one `arr_we` pulse per distinct loaded slot, each pulse falls inside the busy window, and all other locations of the page keep their contents.
- R6: If `wp` is high when `stop_stb` is accepted, there is no `arr_we` pulse and `busy` stays low. The array is unchanged and the staged bytes are discarded.
- R7: A `stop_stb` with no staged bytes, such as an address-only transaction, leaves `busy` low and writes nothing.
- R8: While `busy` is high, `addr_load`, `byte_vld` and `stop_stb` have no effect.
- R9: `rd_data` shows the array word at `rd_addr` one clock after it is presented. This holds whatever the level of `wp`.
- R10: `addr_load` starts a new transaction. It loads the pointer and discards any bytes not yet committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp | input | 1 | Write protect; sampled when the end strobe is accepted |
| addr_load | input | 1 | Strobe: the word address has been received |
| addr_in | input | ADDR_W | Starting word address |
| byte_vld | input | 1 | Strobe: one data byte has been received |
| byte_in | input | DATA_W | Received data byte |
| stop_stb | input | 1 | Strobe: the transaction has ended |
| rd_addr | input | ADDR_W | Read port address |
| rd_data | output | DATA_W | Read port data, one cycle latency |
| busy | output | 1 | Internal write cycle in progress |
| arr_we | output | 1 | Array write strobe |
| arr_waddr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |

## Verification
The bench aims at the page edge. A 20-byte burst starts four slots below the end of a page. If the whole pointer advanced, the burst would spill into the next page. If the wrap were missing, bytes would be lost, and if the overwrite were missing, stale early bytes would survive. A partial write into a full page catches a design that commits untouched slots, which would zero or rewrite its neighbours. An address reload in the middle of a transaction catches a buffer that is not cleared. Protected and empty transactions must never raise `busy`. Traffic injected during a busy window must neither change the array nor leave bytes behind for a later end strobe, and the busy window length is counted to the cycle.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int unsigned PWB_ADDR_W    = 8;
  localparam int unsigned PWB_DATA_W    = 8;
  localparam int unsigned PWB_PAGE_W    = 4;
  localparam int unsigned PWB_WR_CYCLES = 40;
endpackage

// File: rtl/pwb_collect.sv
module pwb_collect #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PAGE_W = 4,
  localparam int unsigned PAGE_N = 1 << PAGE_W,
  localparam int unsigned HI_W   = ADDR_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              bv,
  input  logic [DATA_W-1:0] bd,
  input  logic              clr,
  input  logic [PAGE_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [PAGE_N-1:0] vmask,
  output logic [HI_W-1:0]   page
);
  logic [ADDR_W-1:0] ptr_q;
  logic [DATA_W-1:0] slot_q [PAGE_N];
  logic [PAGE_W-1:0] lo;
  logic              take;

  assign lo   = ptr_q[PAGE_W-1:0];
  assign take = acc && !ld && !clr && bv;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      vmask <= '0;
    end else if (acc) begin
      if (ld) begin
        ptr_q <= ld_addr;
        vmask <= '0;
      end else if (clr) begin
        vmask <= '0;
      end else if (bv) begin
        vmask[lo]           <= 1'b1;
        ptr_q[PAGE_W-1:0]   <= lo + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) slot_q[lo] <= bd;
  end

  assign rd_data = slot_q[rd_idx];
  assign page    = ptr_q[ADDR_W-1:PAGE_W];
endmodule

// File: rtl/pwb_sequencer.sv
module pwb_sequencer #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PAGE_W    = 4,
  parameter int unsigned WR_CYCLES = 40,
  localparam int unsigned PAGE_N = 1 << PAGE_W,
  localparam int unsigned HI_W   = ADDR_W - PAGE_W,
  localparam int unsigned CNT_W  = $clog2(WR_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop,
  input  logic              wp,
  input  logic [PAGE_N-1:0] vmask,
  input  logic [HI_W-1:0]   page,
  output logic [PAGE_W-1:0] rd_idx,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata
);
  logic [CNT_W-1:0]  cnt_q;
  logic [PAGE_N-1:0] snap_q;
  logic [HI_W-1:0]   page_q;
  logic              start, scan_on;

  assign start   = stop && !busy && !wp && (|vmask);
  assign rd_idx  = cnt_q[PAGE_W-1:0];
  assign scan_on = busy && (cnt_q < CNT_W'(PAGE_N));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt_q  <= '0;
      snap_q <= '0;
      page_q <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      cnt_q  <= '0;
      snap_q <= vmask;
      page_q <= page;
    end else if (busy) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(WR_CYCLES - 1)) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      we    <= 1'b0;
      waddr <= '0;
      wdata <= '0;
    end else begin
      we    <= scan_on && snap_q[rd_idx];
      waddr <= {page_q, rd_idx};
      wdata <= rd_data;
    end
  end
endmodule

// File: rtl/pwb_array.sv
module pwb_array #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer
  import pwb_pkg::*;
#(
  parameter int unsigned ADDR_W    = PWB_ADDR_W,
  parameter int unsigned DATA_W    = PWB_DATA_W,
  parameter int unsigned PAGE_W    = PWB_PAGE_W,
  parameter int unsigned WR_CYCLES = PWB_WR_CYCLES,
  localparam int unsigned PAGE_N = 1 << PAGE_W,
  localparam int unsigned HI_W   = ADDR_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              stop_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_waddr,
  output logic [DATA_W-1:0] arr_wdata
);
  logic [PAGE_N-1:0] vmask;
  logic [HI_W-1:0]   page;
  logic [PAGE_W-1:0] scan_idx;
  logic [DATA_W-1:0] slot_data;

  pwb_collect #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_collect (
    .clk     (clk),
    .rst     (rst),
    .acc     (!busy),
    .ld      (addr_load),
    .ld_addr (addr_in),
    .bv      (byte_vld),
    .bd      (byte_in),
    .clr     (stop_stb),
    .rd_idx  (scan_idx),
    .rd_data (slot_data),
    .vmask   (vmask),
    .page    (page)
  );

  pwb_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W),
                  .WR_CYCLES(WR_CYCLES)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .stop    (stop_stb),
    .wp      (wp),
    .vmask   (vmask),
    .page    (page),
    .rd_idx  (scan_idx),
    .rd_data (slot_data),
    .busy    (busy),
    .we      (arr_we),
    .waddr   (arr_waddr),
    .wdata   (arr_wdata)
  );

  pwb_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk   (clk),
    .we    (arr_we),
    .waddr (arr_waddr),
    .wdata (arr_wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned PAGE_W    = 4,
  parameter int unsigned WR_CYCLES = 40,
  localparam int unsigned RUN_W = $clog2(WR_CYCLES + 2)
) (
  input logic              clk,
  input logic              rst,
  input logic              wp,
  input logic              addr_load,
  input logic              byte_vld,
  input logic              stop_stb,
  input logic              busy,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_waddr
);
  logic [RUN_W-1:0] run_len;
  logic             had_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len  <= '0;
      had_byte <= 1'b0;
    end else begin
      run_len <= busy ? run_len + 1'b1 : '0;
      if (!busy) begin
        if (addr_load || stop_stb) had_byte <= 1'b0;
        else if (byte_vld)         had_byte <= 1'b1;
      end
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!busy && !arr_we));

  // R4
  busy_from_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_stb));

  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == RUN_W'(WR_CYCLES)));

  // R5
  we_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);

  // R2
  page_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (arr_we && $past(arr_we)) |->
      (arr_waddr[ADDR_W-1:PAGE_W] == $past(arr_waddr[ADDR_W-1:PAGE_W])));

  // R6
  wp_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_stb && wp && !busy) |=> !busy);

  // R7
  empty_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_stb && !busy && !had_byte) |=> !busy);
endmodule

bind page_write_buffer pwb_checker #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .wp(wp), .addr_load(addr_load), .byte_vld(byte_vld),
  .stop_stb(stop_stb), .busy(busy), .arr_we(arr_we), .arr_waddr(arr_waddr)
);

// File: tb/sim_page_write_buffer.sv
module sim_page_write_buffer;
  localparam int WC = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wp = 1'b0, addr_load = 1'b0, byte_vld = 1'b0, stop_stb = 1'b0;
  logic [7:0] addr_in = '0, byte_in = '0, rd_addr = '0;
  logic [7:0] rd_data, arr_waddr, arr_wdata;
  logic       busy, arr_we;

  always #4 clk = ~clk;

  page_write_buffer #(.WR_CYCLES(WC)) u0 (
    .clk(clk), .rst(rst), .wp(wp), .addr_load(addr_load), .addr_in(addr_in),
    .byte_vld(byte_vld), .byte_in(byte_in), .stop_stb(stop_stb),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .arr_we(arr_we),
    .arr_waddr(arr_waddr), .arr_wdata(arr_wdata)
  );

  int checks = 0, errors = 0, wcnt = 0;
  bit done = 1'b0;

  // reference model
  logic [7:0] ref_mem [256];
  logic [7:0] ref_buf [16];
  logic [15:0] ref_mask = '0;
  logic [7:0] ref_ptr = '0;

  // scoreboard
  logic [7:0] q_exp [$];
  logic [7:0] q_adr [$];
  string      q_tag [$];
  logic       rd_req = 1'b0, fire = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) fire <= rd_req;

  always @(negedge clk) begin
    if (arr_we) wcnt++;
    if (fire && q_exp.size() > 0) begin
      logic [7:0] e, a;
      string t;
      e = q_exp.pop_front(); a = q_adr.pop_front(); t = q_tag.pop_front();
      chk(rd_data === e, $sformatf("%s addr %0h", t, a), rd_data, e);
    end
  end

  task automatic rd_push(input logic [7:0] a, input string tag);
    @(negedge clk);
    rd_addr = a; rd_req = 1'b1;
    q_exp.push_back(ref_mem[a]); q_adr.push_back(a); q_tag.push_back(tag);
  endtask

  task automatic rd_range(input int lo, input int hi, input string tag);
    for (int a = lo; a <= hi; a++) rd_push(8'(a), tag);
    @(negedge clk); rd_req = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_load(input logic [7:0] a, input bit mdl);
    @(negedge clk); addr_load = 1'b1; addr_in = a;
    @(negedge clk); addr_load = 1'b0;
    if (mdl) begin ref_ptr = a; ref_mask = '0; end
  endtask

  task automatic do_byte(input logic [7:0] d, input bit mdl);
    @(negedge clk); byte_vld = 1'b1; byte_in = d;
    @(negedge clk); byte_vld = 1'b0;
    if (mdl) begin
      ref_buf[ref_ptr[3:0]] = d;
      ref_mask[ref_ptr[3:0]] = 1'b1;
      ref_ptr[3:0] = ref_ptr[3:0] + 4'd1;
    end
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_stb = 1'b1;
    @(negedge clk); stop_stb = 1'b0;
  endtask

  // commit model; returns expected write count (0 = no cycle)
  function automatic int m_stop();
    int n = 0;
    if (!wp && ref_mask != 0)
      for (int i = 0; i < 16; i++)
        if (ref_mask[i]) begin ref_mem[{ref_ptr[7:4], 4'(i)}] = ref_buf[i]; n++; end
    ref_mask = '0;
    return n;
  endfunction

  task automatic commit(input string req);
    int n, len;
    n = m_stop();
    wcnt = 0;
    pulse_stop();
    if (n > 0) begin
      chk(busy === 1'b1, {req, " busy after stop (R4)"}, busy, 1);
      len = 0;
      while (busy === 1'b1 && len < 10 * WC) begin len++; @(negedge clk); end
      chk(len == WC, {req, " busy length (R4)"}, len, WC);
      chk(wcnt == n, {req, " write strobes (R5)"}, wcnt, n);
    end else begin
      for (int i = 0; i < 4; i++) begin
        chk(busy === 1'b0, {req, " busy stays low"}, busy, 0);
        @(negedge clk);
      end
      chk(wcnt == 0, {req, " no write strobes"}, wcnt, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(arr_we === 1'b0, "R1 arr_we", arr_we, 0);

    // byte write; nothing before stop (R4)
    do_load(8'h23, 1);
    do_byte(8'hA5, 1);
    wcnt = 0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && wcnt == 0, "R4 nothing before stop", wcnt, 0);
    commit("R4 byte write");
    rd_range(8'h22, 8'h24, "R4 byte write");

    // full page (R2)
    do_load(8'h40, 1);
    for (int i = 0; i < 16; i++) do_byte(8'(8'h10 + i), 1);
    commit("R2 full page");
    rd_range(8'h40, 8'h4F, "R2 full page");

    // wrap with overwrite (R3)
    do_load(8'h5C, 1);
    for (int i = 0; i < 20; i++) do_byte(8'(8'h80 + i), 1);
    commit("R3 wrap");
    rd_range(8'h4F, 8'h60, "R3 wrap in page");

    // reload discards, partial commit (R10, R5)
    do_load(8'h45, 1);
    do_byte(8'h99, 1);
    do_load(8'h47, 1);
    for (int i = 0; i < 3; i++) do_byte(8'(8'hC0 + i), 1);
    commit("R5 partial after R10 reload");
    rd_range(8'h40, 8'h4F, "R5 R10 untouched kept");

    // write protect (R6), reads unaffected (R9)
    wp = 1'b1;
    do_load(8'h40, 1);
    for (int i = 0; i < 4; i++) do_byte(8'hEE, 1);
    commit("R6 protected");
    rd_range(8'h40, 8'h43, "R9 read under wp");
    wp = 1'b0;
    commit("R6 staged bytes discarded");

    // address-only transaction (R7)
    do_load(8'h10, 1);
    commit("R7 empty");

    // traffic while busy ignored (R8)
    do_load(8'h70, 1);
    do_byte(8'h31, 1);
    do_byte(8'h32, 1);
    begin
      int n;
      n = m_stop();
      wcnt = 0;
      pulse_stop();
      chk(busy === 1'b1, "R8 busy started", busy, 1);
      do_load(8'h00, 0);
      for (int i = 0; i < 3; i++) do_byte(8'h5A, 0);
      pulse_stop();
      while (busy === 1'b1) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(busy === 1'b0, "R8 no second cycle", busy, 0);
      chk(wcnt == n, "R8 write count", wcnt, n);
    end
    commit("R8 nothing left staged");
    rd_range(8'h00, 8'h02, "R8 ignored bytes");
    rd_range(8'h70, 8'h71, "R8 accepted bytes");

    repeat (4) @(negedge clk);
    chk(q_exp.size() == 0, "R9 scoreboard drained", q_exp.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule